// File: doc/BRIEF.md
# Nested Three-Level Vectored Interrupt Arbiter

This block sits between a set of peripheral interrupt vector lines and a CPU core. Each of the ten vector lines carries an enable bit and a two-bit priority field. Every cycle the arbiter chooses one candidate among the enabled, requesting vectors. It then compares the candidate's level with the level currently in service. When the candidate's level is strictly higher, the arbiter raises its request to the CPU and presents the candidate's vector address.

The CPU answers with an acknowledge pulse. On that pulse the arbiter saves the level that was in service onto a small internal stack and takes on the accepted level. A later return pulse restores the saved level, and arbitration resumes against it. Only three levels exist and each accepted interrupt raises the level strictly, so nesting is never deeper than three. With nothing in service, the level is a base value below low, and any enabled request can then interrupt. Merging several peripheral sources onto one vector line happens outside this block.

Top module: `nest_irq_arbiter`

## Requirements
- R1: After reset the current level reads 0 (base) and the CPU request stays low while no enabled vector is requesting.
- R2: A vector whose enable bit is 0 never takes part in arbitration, whatever its request line and level field hold.
- R3: Level field codes map as follows: 0 gives low (current-level value 1), 1 gives high (value 2), and both 2 and 3 give highest (value 3).
- R4: The CPU request is high only when the chosen candidate's level is strictly above the current level. An equal or lower level raises no request.
- R5: Among enabled requesting vectors, the one at the highest level is chosen.
- R6: Among chosen-level ties, the vector with the smallest index (smallest address) wins.
- R7: The vector address equals 0x03 + 8 × index, giving 0x03 for vector 0 up to 0x4B for vector 9.
- R8: An acknowledge while the CPU request is high saves the current level and sets the current level, from the next cycle, to the accepted vector's level.
- R9: A return restores the most recently saved level on the next cycle. A return with nothing in service leaves the level at base.
- R10: An acknowledge while the CPU request is low has no effect. When acknowledge and return arrive in the same cycle, only the return acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_req | input | NVEC | Request line per vector |
| vec_en | input | NVEC | Enable bit per vector |
| vec_lvl | input | 2*NVEC | Level code per vector, field i at bits 2i+1:2i |
| cpu_ack | input | 1 | CPU accepts the presented vector |
| cpu_reti | input | 1 | CPU returns from the current handler |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | AW | Address of the chosen vector |
| cur_level | output | 2 | Level in service: 0 base, 1 low, 2 high, 3 highest |

## Verification
A corrupted saved-level stack cannot be seen right away. It becomes visible only when returns unwind the nest: `cur_level` takes a wrong value on the cycle after the return, and from that cycle on requests are masked or admitted wrongly. For that reason the bench nests three levels deep and then unwinds each level, checking the level and the request line at every step. A wrong current-level register shows one cycle after an acknowledge, as a wrong `cur_level` and a wrong `cpu_irq` for the requests still pending.

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter #(
  parameter int NVEC     = 10,
  parameter int AW       = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NVEC-1:0]   vec_req,
  input  logic [NVEC-1:0]   vec_en,
  input  logic [2*NVEC-1:0] vec_lvl,
  input  logic              cpu_ack,
  input  logic              cpu_reti,
  output logic              cpu_irq,
  output logic [AW-1:0]     vec_addr,
  output logic [1:0]        cur_level
);
  localparam int IW    = (NVEC > 1) ? $clog2(NVEC) : 1;
  localparam int DEPTH = 3;
  localparam int DW    = $clog2(DEPTH + 1);

  logic [1:0]    win_lvl;
  logic [IW-1:0] win_idx;
  logic [1:0]    stk [DEPTH];
  logic [DW-1:0] depth;

  always_comb begin
    win_lvl = 2'd0;
    win_idx = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      logic [1:0] code, lv;
      code = vec_lvl[2*i +: 2];
      lv   = (code == 2'd0) ? 2'd1 : (code == 2'd1) ? 2'd2 : 2'd3;
      if (vec_req[i] && vec_en[i] && lv >= win_lvl) begin
        win_lvl = lv;
        win_idx = IW'(i);
      end
    end
  end

  assign cpu_irq  = (win_lvl > cur_level);
  assign vec_addr = AW'(VEC_BASE) + AW'(win_idx) * AW'(VEC_STEP);

  wire take = cpu_ack && cpu_irq && !cpu_reti;
  wire back = cpu_reti && (depth != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_level <= 2'd0;
      depth     <= '0;
      for (int k = 0; k < DEPTH; k++) stk[k] <= 2'd0;
    end else if (back) begin
      cur_level <= stk[DW'(depth - 1'b1)];
      depth     <= depth - 1'b1;
    end else if (take) begin
      stk[depth] <= cur_level;
      cur_level  <= win_lvl;
      depth      <= depth + 1'b1;
    end
  end

  a_r4_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ((vec_req & vec_en) != '0));
  a_r4_top_never_preempted: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level == 2'd3 |-> !cpu_irq);
  a_r8_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_irq && !cpu_reti) |=> cur_level > $past(cur_level));
  a_r8_stack_room: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_irq) |-> depth < DW'(DEPTH));
  a_r9_level_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_reti && depth != '0) |=> cur_level < $past(cur_level));
  a_r9_empty_is_base: assert property (@(posedge clk) disable iff (!rst_n)
    depth == '0 |-> cur_level == 2'd0);
  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_irq && !cpu_reti) |=> $stable(cur_level));
endmodule

// File: tb/nest_irq_arbiter_bench.sv
module nest_irq_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  req = '0, en = '0;
  logic [19:0] lvl = '0;
  logic        ack = 1'b0, reti = 1'b0;
  logic        irq;
  logic [7:0]  addr;
  logic [1:0]  cur;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  nest_irq_arbiter u_nest_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .vec_req(req), .vec_en(en), .vec_lvl(lvl),
    .cpu_ack(ack), .cpu_reti(reti), .cpu_irq(irq), .vec_addr(addr), .cur_level(cur)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic src(int i, bit on, bit e, int code);
    req[i] = on; en[i] = e; lvl[2*i +: 2] = 2'(code);
  endtask

  task automatic clear();
    @(negedge clk); req = '0; en = '0; lvl = '0; #1;
  endtask

  task automatic pulse(bit a, bit r);
    @(negedge clk); ack = a; reti = r;
    @(negedge clk); ack = 1'b0; reti = 1'b0; #1;
  endtask

  task automatic t_reset();
    #1; chk("R1 level", cur, 0); chk("R1 irq", irq, 0);
  endtask

  task automatic t_disabled();
    clear(); src(2, 1, 0, 2); #1;
    chk("R2 disabled irq", irq, 0);
    src(8, 1, 1, 0); #1;
    chk("R2 disabled skipped addr", addr, 8'h43);
    pulse(1, 0); chk("R2 level after ack", cur, 1);
    pulse(0, 1); chk("R9 back to base", cur, 0);
  endtask

  task automatic t_priority();
    clear(); src(4, 1, 1, 0); #1;
    chk("R7 single irq", irq, 1); chk("R7 addr v4", addr, 8'h23);
    src(1, 1, 1, 0); src(7, 1, 1, 2); #1;
    chk("R5 highest wins", addr, 8'h3B);
    src(5, 1, 1, 3); #1;
    chk("R3 code3 ties code2, R6 lower wins", addr, 8'h2B);
    clear(); src(6, 1, 1, 1); src(3, 1, 1, 1); #1;
    chk("R6 tie lowest index", addr, 8'h1B);
    clear(); src(9, 1, 1, 1); src(0, 1, 1, 0); #1;
    chk("R7 addr v9", addr, 8'h4B);
    clear(); src(0, 1, 1, 0); #1;
    chk("R7 addr v0", addr, 8'h03);
  endtask

  task automatic t_nesting();
    clear(); src(6, 1, 1, 0); #1;
    pulse(1, 0); chk("R8 low accepted", cur, 1);
    chk("R4 equal level masked", irq, 0);
    src(2, 1, 1, 1); #1;
    chk("R4 higher admitted", irq, 1); chk("R7 addr v2", addr, 8'h13);
    pulse(1, 0); chk("R3 code1 is high", cur, 2);
    src(1, 1, 1, 0); #1; chk("R4 lower masked", irq, 0);
    src(9, 1, 1, 2); #1;
    pulse(1, 0); chk("R3 code2 is highest", cur, 3);
    src(0, 1, 1, 3); #1; chk("R4 highest not nested", irq, 0);
    pulse(0, 1); chk("R9 pop to high", cur, 2);
    chk("R9 reevaluate irq", irq, 1);
    pulse(0, 1); chk("R9 pop to low", cur, 1);
    pulse(0, 1); chk("R9 pop to base", cur, 0);
    pulse(0, 1); chk("R9 empty return", cur, 0);
  endtask

  task automatic t_ack_rules();
    clear(); pulse(1, 0); chk("R10 idle ack", cur, 0);
    src(3, 1, 1, 0); #1; pulse(1, 0); chk("R8 enter low", cur, 1);
    src(4, 1, 1, 2); #1; pulse(1, 1);
    chk("R10 return wins over ack", cur, 0);
    chk("R10 irq after", irq, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset(); t_disabled(); t_priority(); t_nesting(); t_ack_rules();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule